// File: doc/BRIEF.md
# Slot Bus Tenure Guard

This block sits on the backplane beside one slot of a daisy-chained grant bus. It counts how many consecutive clock cycles the card in that slot has owned the bus. Once a tenure reaches the configured limit, the guard places the slot in a penalty state. In that state the chain's grant input is routed straight to the chain's grant output, and the card's own grant input is held low, so the card takes no further part in arbitration. Only these two grant paths are switched; the data and address lines are left alone.

While penalised, the slot earns back credit. A saturating credit counter is cleared when the penalty starts. It then rises by one on every cycle the card does not own the bus and falls by one on every cycle it does. The penalty ends once the credit has reached a re-admission level given on an input port. A sticky overrun flag records that at least one penalty has happened since reset.

Top module: `slot_tenure_guard`

## Requirements
- R1: While no penalty is active, `card_grant_in` equals `grant_from_chain` and `grant_to_chain` equals `card_grant_out`, combinationally.
- R2: A penalty starts on the TENURE_MAX-th consecutive rising edge that samples `card_owns_bus` high. After fewer such edges, no penalty is active.
- R3: The tenure count restarts whenever a rising edge samples `card_owns_bus` low, so ownership that is broken by an idle cycle never triggers a penalty.
- R4: While a penalty is active, `card_grant_in` is 0 and `grant_to_chain` equals `grant_from_chain`, whatever `card_grant_out` is.
- R5: Credit is cleared to 0 on the edge where a penalty starts. On every other edge it rises by one when `card_owns_bus` is low and falls by one when it is high. It saturates at 0 and at 2^CREDIT_W-1, and it never changes by more than one.
- R6: A rising edge ends the penalty when the credit held before that edge is at least `readmit_level`. With level 0, the penalty therefore ends on the edge after it starts. With level L>0 and no ownership during the penalty, it ends on the (L+1)-th idle edge.
- R7: `overrun_seen` is set when a penalty starts. It stays set after the penalty ends and is cleared only by reset.
- R8: After reset, `penalty` and `overrun_seen` are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| readmit_level | input | CREDIT_W | Credit needed to leave the penalty |
| grant_from_chain | input | 1 | Grant arriving from the upstream slot |
| card_grant_out | input | 1 | Grant passed on by the card |
| card_owns_bus | input | 1 | Card reports that it currently owns the bus |
| card_grant_in | output | 1 | Gated grant delivered to the card |
| grant_to_chain | output | 1 | Grant forwarded to the downstream slot |
| penalty | output | 1 | Slot is bypassed |
| overrun_seen | output | 1 | Sticky record of any penalty since reset |

## Verification
On every cycle, the embedded assertions check these properties:
- credit moves by at most one, and is zero when a penalty begins;
- a penalty only begins while the card owns the bus, and always sets the sticky flag, which never drops;
- a penalty only ends with sufficient credit behind it;
- the tenure count stays bounded.

Only the bench scenarios can show the exact cycle of entry and exit and the grant routing in both modes. These scenarios cover:
- entry on exactly the limit-th owning edge, with a hogging card;
- exit on exactly the (level+1)-th idle edge, across a sweep of re-admission levels and extra hold times;
- the delay added when the card grabs the bus again mid-penalty.

// File: rtl/slot_tenure_guard.sv
module slot_tenure_guard #(
  parameter int TENURE_MAX = 16,
  parameter int CREDIT_W   = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [CREDIT_W-1:0] readmit_level,
  input  logic                grant_from_chain,
  input  logic                card_grant_out,
  input  logic                card_owns_bus,
  output logic                card_grant_in,
  output logic                grant_to_chain,
  output logic                penalty,
  output logic                overrun_seen
);

  localparam int TEN_W = $clog2(TENURE_MAX + 1);
  localparam logic [TEN_W-1:0]    TEN_TOP  = TEN_W'(TENURE_MAX);
  localparam logic [TEN_W-1:0]    TEN_LAST = TEN_W'(TENURE_MAX - 1);
  localparam logic [CREDIT_W-1:0] CR_TOP   = '1;

  logic [TEN_W-1:0]    tenure_q;
  logic [CREDIT_W-1:0] credit_q;
  logic                penalty_q, overrun_q;
  logic                hit, release_now;

  assign hit         = card_owns_bus && !penalty_q && (tenure_q >= TEN_LAST);
  assign release_now = penalty_q && (credit_q >= readmit_level);

  always_ff @(posedge clk) begin
    if (!rst_n)                   tenure_q <= '0;
    else if (!card_owns_bus)      tenure_q <= '0;
    else if (tenure_q != TEN_TOP) tenure_q <= tenure_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)             credit_q <= CR_TOP;
    else if (hit)           credit_q <= '0;
    else if (card_owns_bus) credit_q <= (credit_q == '0) ? credit_q : credit_q - 1'b1;
    else                    credit_q <= (credit_q == CR_TOP) ? credit_q : credit_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      penalty_q <= 1'b0;
      overrun_q <= 1'b0;
    end else begin
      if (hit)              penalty_q <= 1'b1;
      else if (release_now) penalty_q <= 1'b0;
      if (hit)              overrun_q <= 1'b1;
    end
  end

  assign card_grant_in  = penalty_q ? 1'b0 : grant_from_chain;
  assign grant_to_chain = penalty_q ? grant_from_chain : card_grant_out;
  assign penalty        = penalty_q;
  assign overrun_seen   = overrun_q;

  AST_ENTRY_WHILE_OWNED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(penalty_q) |-> $past(card_owns_bus)); // R2
  AST_TENURE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    tenure_q <= TEN_TOP); // R3
  AST_CREDIT_ZERO_ON_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(penalty_q) |-> credit_q == '0); // R5
  AST_CREDIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(penalty_q) |-> (credit_q == $past(credit_q)
      || {1'b0, credit_q} == {1'b0, $past(credit_q)} + (CREDIT_W+1)'(1)
      || {1'b0, credit_q} + (CREDIT_W+1)'(1) == {1'b0, $past(credit_q)})); // R5
  AST_EXIT_HAS_CREDIT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(penalty_q) |-> $past(credit_q) >= $past(readmit_level)); // R6
  AST_FLAG_ON_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(penalty_q) |-> overrun_q); // R7
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    overrun_q |=> overrun_q); // R7

endmodule

// File: tb/sim_slot_tenure_guard.sv
`timescale 1ns/1ps
module sim_slot_tenure_guard;
  localparam int TN = 4;
  localparam int CW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [CW-1:0] readmit_level = '0;
  logic grant_from_chain = 1'b0, card_grant_out = 1'b0, card_owns_bus = 1'b0;
  logic card_grant_in, grant_to_chain, penalty, overrun_seen;
  int n_cmp = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  slot_tenure_guard #(.TENURE_MAX(TN), .CREDIT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .readmit_level(readmit_level),
    .grant_from_chain(grant_from_chain), .card_grant_out(card_grant_out),
    .card_owns_bus(card_owns_bus), .card_grant_in(card_grant_in),
    .grant_to_chain(grant_to_chain), .penalty(penalty), .overrun_seen(overrun_seen));

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; card_owns_bus = 1'b0; grant_from_chain = 1'b0; card_grant_out = 1'b0;
    step(2);
    rst_n = 1'b1;
  endtask

  initial begin
    #(5.0 * 200000);
    n_bad++;
    $display("FAIL watchdog: got running expected finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    do_reset();
    chk("R8 penalty", penalty, 1'b0);
    chk("R8 flag", overrun_seen, 1'b0);

    for (int g = 0; g < 4; g++) begin
      grant_from_chain = g[0]; card_grant_out = g[1]; #1;
      chk("R1 card_grant_in", card_grant_in, g[0]);
      chk("R1 grant_to_chain", grant_to_chain, g[1]);
    end

    for (int l = 1; l < TN; l++) begin
      do_reset();
      card_owns_bus = 1'b1;
      for (int k = 0; k < l; k++) begin step(1); chk("R2 below limit", penalty, 1'b0); end
      card_owns_bus = 1'b0; step(1);
      chk("R2 below limit idle", penalty, 1'b0);
    end

    do_reset();
    card_owns_bus = 1'b1; step(TN-1);
    card_owns_bus = 1'b0; step(1);
    card_owns_bus = 1'b1; step(TN-1);
    chk("R3 restart", penalty, 1'b0);
    step(1);
    chk("R2 limit after restart", penalty, 1'b1);

    do_reset();
    card_owns_bus = 1'b1; step(TN-1);
    chk("R2 one short", penalty, 1'b0);
    step(1);
    chk("R2 exact entry", penalty, 1'b1);
    chk("R7 set", overrun_seen, 1'b1);
    for (int g = 0; g < 4; g++) begin
      grant_from_chain = g[0]; card_grant_out = g[1]; #1;
      chk("R4 card blocked", card_grant_in, 1'b0);
      chk("R4 bypass", grant_to_chain, g[0]);
    end

    for (int thr = 1; thr <= 6; thr++) begin
      for (int h = 0; h < 3; h++) begin
        do_reset();
        readmit_level = CW'(thr);
        card_owns_bus = 1'b1; step(TN + h);
        chk("R2 hog penalised", penalty, 1'b1);
        card_owns_bus = 1'b0; step(thr);
        chk("R6 still out", penalty, 1'b1);
        step(1);
        chk("R6 readmitted", penalty, 1'b0);
        chk("R7 sticky", overrun_seen, 1'b1);
      end
    end
    do_reset();
    chk("R7 reset clears", overrun_seen, 1'b0);

    readmit_level = '0;
    card_owns_bus = 1'b1; step(TN);
    chk("R6 level0 entry", penalty, 1'b1);
    step(1);
    chk("R6 level0 exit", penalty, 1'b0);

    do_reset();
    readmit_level = CW'(3);
    card_owns_bus = 1'b1; step(TN);
    card_owns_bus = 1'b0; step(2);
    card_owns_bus = 1'b1; step(1);
    card_owns_bus = 1'b0; step(2);
    chk("R5 decrement delays exit", penalty, 1'b1);
    step(1);
    chk("R5 exit after regain", penalty, 1'b0);

    do_reset();
    readmit_level = '1;
    card_owns_bus = 1'b1; step(TN);
    card_owns_bus = 1'b0; step(15);
    chk("R5 top level still out", penalty, 1'b1);
    step(1);
    chk("R5 top level exit", penalty, 1'b0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule